// File: doc/BRIEF.md
# Prescaled Fixed-Resolution PWM Generator

This block produces one pulse-width-modulated output whose period comes from a chain of three dividers. The first stage picks one of three reference clock enables. The second stage divides by a ratio of 1, 3, 5 or 6. The third stage divides by 2^M. The result steps a 9-bit counter, so one output period is always 512 steps of the divided clock. The output is high while the counter is below the duty value. It can be inverted, and it rests at its inactive level while the generator is disabled.

The configuration port is register-style and carries no stream data. All control pins are plain levels. A single write strobe captures every field at once. Source, pre-divider, exponent and duty go into a pending copy. This copy becomes active together at the next counter wrap, so a period and its duty never mix. A staging input can block that transfer while software issues several writes. The transfer then happens at the first wrap after staging is released. Enable and polarity take effect as soon as they are written. A rising enable restarts all three counters and loads the pending settings at once.

Top module: `pwm_prescaled`

## Requirements
- R1: While reset is asserted and after it is released, the output is low. All settings are zero (source 0, pre-divider index 0, exponent 0, duty 0), the generator is disabled and polarity is normal.
- R2: With the selected enable active every clock, one period lasts 512 × r × 2^M clocks. The ratio r is 1, 3, 5 or 6 for pre-divider index 0, 1, 2 or 3, and M is the 3-bit exponent (0 to 7).
- R3: Source index 0, 1 and 2 select `ref_tick[0]`, `ref_tick[1]` and `ref_tick[2]`. Index 3 behaves exactly like index 2. Each period spans 512 × r × 2^M pulses of the selected enable.
- R4: While running, the output is high for exactly the duty value's count of the 512 steps in each period. Duty 0 gives a constant low and duty 511 gives 511 high steps.
- R5: A duty value above 511 written on the 10-bit duty field is stored as 511.
- R6: Source, pre-divider, exponent and duty writes to a running generator take effect only at the next wrap of the 9-bit counter from 511 to 0. Until then the output follows the old settings.
- R7: While `cfg_stage` is high, a wrap does not transfer pending settings. The first wrap after it falls does.
- R8: With `cfg_invert` = 1 the output is inverted. While the generator is disabled, the output equals `cfg_invert`: low for normal polarity, high for inverted.
- R9: A write that raises enable loads the pending settings and clears all counters on the next clock. The first active step is presented on the clock after that, at two edges after the write edge.
- R10: The output is registered. It reflects the counter, duty, enable and polarity state of the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 3 | Reference clock enables (slow, mid, fast), sampled on clk |
| cfg_we | input | 1 | Write strobe capturing all cfg_* fields |
| cfg_src | input | 2 | Reference source index |
| cfg_prediv | input | 2 | Pre-divider index (ratios 1, 3, 5, 6) |
| cfg_exp | input | 3 | Power-of-two exponent M |
| cfg_duty | input | 10 | Requested duty, clamped to 511 |
| cfg_enable | input | 1 | Generator enable |
| cfg_invert | input | 1 | Output polarity inversion |
| cfg_stage | input | 1 | Blocks pending-to-active transfer while high |
| pwm_out | output | 1 | PWM output |

## Verification
Each result falls due at a different edge. Enable and polarity appear on the output one edge after the write edge. A rising enable shows its first active step two edges after the write. Duty and period changes appear only after the counter's next wrap, which can lie up to 512 × r × 2^M enabled clocks away. The bench drives inputs on the falling edge. Its model advances on the rising edge with the same latency rules, and it compares the output on the following falling edge. The dedicated checks therefore count falling edges from the write or from an observed rising output edge before sampling.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int CNT_W     = 9;
  localparam int SRC_W     = 2;
  localparam int PD_W      = 2;
  localparam int EXP_W     = 3;
  localparam int DUTY_IN_W = 10;
  localparam int NUM_SRC   = 3;
  localparam int PD_CNT_W  = 3;
  localparam int EXP_CNT_W = (1 << EXP_W) - 1;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [PD_W-1:0]  pd;
    logic [EXP_W-1:0] m;
    logic [CNT_W-1:0] duty;
  } pwm_cfg_t;

  // Terminal count of the pre-divider: ratios 1, 3, 5, 6.
  function automatic logic [PD_CNT_W-1:0] pd_terminal(input logic [PD_W-1:0] idx);
    logic [PD_CNT_W-1:0] t;
    case (idx)
      2'd0:    t = PD_CNT_W'(0);
      2'd1:    t = PD_CNT_W'(2);
      2'd2:    t = PD_CNT_W'(4);
      default: t = PD_CNT_W'(5);
    endcase
    return t;
  endfunction

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_pkg::*;
#(
  parameter int DW = DUTY_IN_W,
  parameter int CW = CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SRC_W-1:0] cfg_src,
  input  logic [PD_W-1:0]  cfg_prediv,
  input  logic [EXP_W-1:0] cfg_exp,
  input  logic [DW-1:0]    cfg_duty,
  input  logic             cfg_enable,
  input  logic             cfg_invert,
  input  logic             cfg_stage,
  input  logic             wrap,
  output pwm_cfg_t         pend,
  output pwm_cfg_t         act,
  output logic             inv_q,
  output logic             run,
  output logic             load
);

  localparam int DUTY_MAX = (1 << CW) - 1;

  logic          en_q;
  logic          en_prev;
  logic [CW-1:0] duty_clamped;

  always_comb begin
    if (cfg_duty > DW'(DUTY_MAX)) duty_clamped = CW'(DUTY_MAX);
    else                          duty_clamped = cfg_duty[CW-1:0];
  end

  assign load = en_q & ~en_prev;
  assign run  = en_q & en_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      act     <= '0;
      en_q    <= 1'b0;
      en_prev <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      en_prev <= en_q;
      if (cfg_we) begin
        pend.src  <= cfg_src;
        pend.pd   <= cfg_prediv;
        pend.m    <= cfg_exp;
        pend.duty <= duty_clamped;
        en_q      <= cfg_enable;
        inv_q     <= cfg_invert;
      end
      if (load || (wrap && !cfg_stage)) act <= pend;
    end
  end

endmodule

// File: rtl/pwm_clk_div.sv
module pwm_clk_div
  import pwm_pkg::*;
#(
  parameter int NS  = NUM_SRC,
  parameter int PCW = PD_CNT_W,
  parameter int ECW = EXP_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NS-1:0]    ref_tick,
  input  logic [SRC_W-1:0] src,
  input  logic [PD_W-1:0]  pd,
  input  logic [EXP_W-1:0] m,
  input  logic             clr,
  output logic             step
);

  logic [NS-1:0]  hit;
  logic           tick;
  logic [PCW-1:0] pd_cnt;
  logic [ECW-1:0] ex_cnt;
  logic [ECW-1:0] ex_limit;
  logic           pd_last;
  logic           ex_last;

  // One match term per source; the last source also covers unused indices.
  for (genvar g = 0; g < NS; g++) begin : g_src
    if (g == NS - 1) begin : g_top
      assign hit[g] = ref_tick[g] & (src >= SRC_W'(g));
    end else begin : g_mid
      assign hit[g] = ref_tick[g] & (src == SRC_W'(g));
    end
  end

  assign tick     = |hit;
  assign ex_limit = ECW'((32'd1 << m) - 32'd1);
  assign pd_last  = (pd_cnt == pd_terminal(pd));
  assign ex_last  = (ex_cnt == ex_limit);
  assign step     = tick & pd_last & ex_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_cnt <= '0;
      ex_cnt <= '0;
    end else if (clr) begin
      pd_cnt <= '0;
      ex_cnt <= '0;
    end else if (tick) begin
      if (pd_last) begin
        pd_cnt <= '0;
        ex_cnt <= ex_last ? '0 : ex_cnt + 1'b1;
      end else begin
        pd_cnt <= pd_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
  import pwm_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic          step,
  input  logic [CW-1:0] duty,
  input  logic          inv,
  output logic [CW-1:0] cnt,
  output logic          wrap,
  output logic          pwm_out
);

  assign wrap = run & step & (cnt == {CW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pwm_out <= 1'b0;
    end else begin
      if (clr)       cnt <= '0;
      else if (step) cnt <= cnt + 1'b1;
      pwm_out <= run ? ((cnt < duty) ^ inv) : inv;
    end
  end

endmodule

// File: rtl/pwm_prescaled.sv
module pwm_prescaled
  import pwm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   ref_tick,
  input  logic                 cfg_we,
  input  logic [SRC_W-1:0]     cfg_src,
  input  logic [PD_W-1:0]      cfg_prediv,
  input  logic [EXP_W-1:0]     cfg_exp,
  input  logic [DUTY_IN_W-1:0] cfg_duty,
  input  logic                 cfg_enable,
  input  logic                 cfg_invert,
  input  logic                 cfg_stage,
  output logic                 pwm_out
);

  pwm_cfg_t         pend;
  pwm_cfg_t         act;
  logic             inv_q;
  logic             run;
  logic             load;
  logic             wrap;
  logic             step;
  logic [CNT_W-1:0] cnt;

  pwm_cfg_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_src    (cfg_src),
    .cfg_prediv (cfg_prediv),
    .cfg_exp    (cfg_exp),
    .cfg_duty   (cfg_duty),
    .cfg_enable (cfg_enable),
    .cfg_invert (cfg_invert),
    .cfg_stage  (cfg_stage),
    .wrap       (wrap),
    .pend       (pend),
    .act        (act),
    .inv_q      (inv_q),
    .run        (run),
    .load       (load)
  );

  pwm_clk_div u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .src      (act.src),
    .pd       (act.pd),
    .m        (act.m),
    .clr      (~run),
    .step     (step)
  );

  pwm_wave u_wave (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (~run),
    .run     (run),
    .step    (step),
    .duty    (act.duty),
    .inv     (inv_q),
    .cnt     (cnt),
    .wrap    (wrap),
    .pwm_out (pwm_out)
  );

endmodule

// File: rtl/pwm_prescaled_chk.sv
module pwm_prescaled_chk
  import pwm_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 run,
  input logic                 load,
  input logic                 wrap,
  input logic                 step,
  input logic                 inv_q,
  input logic                 cfg_we,
  input logic                 cfg_stage,
  input logic [DUTY_IN_W-1:0] cfg_duty,
  input logic [CNT_W-1:0]     cnt,
  input logic [CNT_W-1:0]     pend_duty,
  input logic [CNT_W-1:0]     act_duty,
  input logic [$bits(pwm_cfg_t)-1:0] act_bits,
  input logic                 pwm_out
);

  localparam int DMAX = (1 << CNT_W) - 1;

  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pwm_out == $past(inv_q));

  // R4
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_duty == '0) |=> pwm_out == $past(inv_q));

  // R5
  duty_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_duty > DUTY_IN_W'(DMAX)) |=> pend_duty == CNT_W'(DMAX));

  // R6
  boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !load) |=> $stable(act_bits));

  // R7
  stage_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && cfg_stage) |=> $stable(act_bits));

  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == '0);

  // R2
  step_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !step) |=> $stable(cnt));

endmodule

bind pwm_prescaled pwm_prescaled_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .load      (load),
  .wrap      (wrap),
  .step      (step),
  .inv_q     (inv_q),
  .cfg_we    (cfg_we),
  .cfg_stage (cfg_stage),
  .cfg_duty  (cfg_duty),
  .cnt       (cnt),
  .pend_duty (pend.duty),
  .act_duty  (act.duty),
  .act_bits  (act),
  .pwm_out   (pwm_out)
);

// File: tb/pwm_prescaled_test.sv
module pwm_prescaled_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ref_tick = 3'b000;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_src = '0;
  logic [1:0] cfg_prediv = '0;
  logic [2:0] cfg_exp = '0;
  logic [9:0] cfg_duty = '0;
  logic       cfg_enable = 1'b0;
  logic       cfg_invert = 1'b0;
  logic       cfg_stage = 1'b0;
  logic       pwm_out;

  always #10 clk = ~clk;

  pwm_prescaled uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cfg_we(cfg_we),
    .cfg_src(cfg_src), .cfg_prediv(cfg_prediv), .cfg_exp(cfg_exp),
    .cfg_duty(cfg_duty), .cfg_enable(cfg_enable), .cfg_invert(cfg_invert),
    .cfg_stage(cfg_stage), .pwm_out(pwm_out)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";
  int    cyc = 0;

  // Reference enables: fast every clock, mid every 3rd, slow every 7th.
  always @(negedge clk) begin
    cyc = cyc + 1;
    ref_tick[2] = 1'b1;
    ref_tick[1] = (cyc % 3 == 0);
    ref_tick[0] = (cyc % 7 == 0);
  end

  // Behavioural model: position in ticks within the period.
  int ratio_tab [4] = '{1, 3, 5, 6};
  int sh_src, sh_pd, sh_m, sh_duty;
  int a_src, a_pd, a_m, a_duty;
  int m_pos;
  bit m_en, m_enp, m_inv, m_out;

  always @(posedge clk or negedge rst_n) begin
    int  dv;
    int  idx;
    bit  run, load, wrap, tk;
    if (!rst_n) begin
      sh_src = 0; sh_pd = 0; sh_m = 0; sh_duty = 0;
      a_src = 0; a_pd = 0; a_m = 0; a_duty = 0;
      m_pos = 0; m_en = 0; m_enp = 0; m_inv = 0; m_out = 0;
    end else begin
      run  = m_en && m_enp;
      load = m_en && !m_enp;
      dv   = ratio_tab[a_pd] << a_m;
      idx  = (a_src > 2) ? 2 : a_src;
      tk   = ref_tick[idx];
      wrap = run && tk && (m_pos == 512 * dv - 1);
      m_out = run ? (((m_pos / dv) < a_duty) ^ m_inv) : m_inv;
      if (!run) m_pos = 0;
      else if (tk) m_pos = wrap ? 0 : m_pos + 1;
      if (load || (wrap && !cfg_stage)) begin
        a_src = sh_src; a_pd = sh_pd; a_m = sh_m; a_duty = sh_duty;
      end
      m_enp = m_en;
      if (cfg_we) begin
        sh_src  = int'(cfg_src);
        sh_pd   = int'(cfg_prediv);
        sh_m    = int'(cfg_exp);
        sh_duty = (int'(cfg_duty) > 511) ? 511 : int'(cfg_duty);
        m_en    = cfg_enable;
        m_inv   = cfg_invert;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R10 latency built in).
  always @(negedge clk) begin
    if (!finished) check({cur_req, " cycle"}, int'(pwm_out), int'(m_out));
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic wr(input int src, input int pd, input int m, input int duty,
                    input bit en, input bit inv);
    @(negedge clk);
    cfg_src = 2'(src); cfg_prediv = 2'(pd); cfg_exp = 3'(m);
    cfg_duty = 10'(duty); cfg_enable = en; cfg_invert = inv; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Disable then enable; checks the restart timing of R9.
  task automatic restart(input int src, input int pd, input int m,
                         input int duty, input bit inv);
    wr(src, pd, m, duty, 1'b0, inv);
    wr(src, pd, m, duty, 1'b1, inv);
    @(negedge clk);
    check("R9 load edge", int'(pwm_out), int'(inv));
    @(negedge clk);
    check("R9 first step", int'(pwm_out), int'(!inv));
  endtask

  task automatic measure_period(output int p);
    bit prev;
    int guard;
    prev = pwm_out; guard = 0;
    do begin @(negedge clk); guard++; end
    while (!(pwm_out && !prev) && guard < 60000 && ((prev = pwm_out) || 1));
    p = 0; prev = pwm_out;
    do begin @(negedge clk); p++; end
    while (!(pwm_out && !prev) && p < 60000 && ((prev = pwm_out) || 1));
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
  endtask

  initial begin
    int p, h;
    cur_req = "R1";
    repeat (4) @(negedge clk);
    check("R1 in reset", int'(pwm_out), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 after reset", int'(pwm_out), 0);

    cur_req = "R2";
    restart(2, 0, 0, 100, 1'b0);
    measure_period(p); check("R2 r1 M0", p, 512);
    restart(2, 1, 1, 100, 1'b0);
    measure_period(p); check("R2 r3 M1", p, 3072);
    restart(2, 2, 0, 100, 1'b0);
    measure_period(p); check("R2 r5 M0", p, 2560);
    restart(2, 3, 2, 100, 1'b0);
    measure_period(p); check("R2 r6 M2", p, 12288);

    cur_req = "R3";
    restart(1, 0, 0, 100, 1'b0);
    measure_period(p); check("R3 mid source", p, 1536);
    restart(0, 0, 0, 100, 1'b0);
    measure_period(p); check("R3 slow source", p, 3584);
    restart(3, 0, 0, 100, 1'b0);
    measure_period(p); check("R3 index 3", p, 512);

    cur_req = "R4";
    restart(2, 0, 0, 37, 1'b0);
    count_high(512, h); check("R4 duty 37", h, 37);
    wr(2, 0, 0, 0, 1'b1, 1'b0);
    repeat (1100) @(negedge clk);
    count_high(512, h); check("R4 duty 0", h, 0);
    wr(2, 0, 0, 511, 1'b1, 1'b0);
    repeat (1100) @(negedge clk);
    count_high(512, h); check("R4 duty 511", h, 511);

    cur_req = "R5";
    wr(2, 0, 0, 700, 1'b1, 1'b0);
    repeat (1100) @(negedge clk);
    count_high(512, h); check("R5 clamp 700", h, 511);

    cur_req = "R6";
    restart(2, 0, 0, 100, 1'b0);
    repeat (200) @(negedge clk);
    wr(2, 0, 0, 400, 1'b1, 1'b0);
    repeat (50) @(negedge clk);
    check("R6 old duty holds", int'(pwm_out), 0);
    repeat (600) @(negedge clk);
    count_high(512, h); check("R6 new duty at wrap", h, 400);

    cur_req = "R7";
    cfg_stage = 1'b1;
    wr(2, 0, 0, 300, 1'b1, 1'b0);
    repeat (1100) @(negedge clk);
    count_high(512, h); check("R7 staged", h, 400);
    cfg_stage = 1'b0;
    repeat (1100) @(negedge clk);
    count_high(512, h); check("R7 released", h, 300);

    cur_req = "R8";
    wr(2, 0, 0, 100, 1'b0, 1'b1);
    @(negedge clk);
    check("R8 idle inverted", int'(pwm_out), 1);
    repeat (20) @(negedge clk);
    check("R8 idle stays high", int'(pwm_out), 1);
    restart(2, 0, 0, 100, 1'b1);
    count_high(512, h); check("R8 inverted duty", h, 412);
    wr(2, 0, 0, 100, 1'b0, 1'b0);
    @(negedge clk);
    check("R8 idle normal", int'(pwm_out), 0);

    repeat (10) @(negedge clk);
    summary();
  end

endmodule